// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose counting logic runs on a separate slow clock. The slow clock stays alive when the bus clock stops. Software controls the watchdog only by writing key words to a key register. One key starts the timer. One key refreshes the counter. One key opens the two configuration registers for writing: a prescaler code and a reload value.

A configuration write first lands in a holding register in the bus domain. A toggle handshake then carries it into the slow domain. Until the slow side has taken the new value, a pending bit for that register reads 1 in the status register.

In the slow domain, a prescaler makes one count-enable tick every 4·2^code slow cycles. Each tick decrements a 12-bit down-counter. When the counter reaches zero, the block raises a one-cycle reset pulse, reloads the counter and keeps running. Nothing short of a slow-domain reset can stop the watchdog once it is started.

A debug-halt input holds both the prescaler and the counter while it is high. That input is assumed to be synchronous to the slow clock.

Top module: `wdt_keyed`

## Requirements
- R1: A write of key 0xCCCC to address 0 starts the watchdog. `wdg_running` rises and `wdg_count` is 0xFFF in the first slow cycle in which it is running.
- R2: When a tick brings the counter to 0, `wdg_rst` is high for exactly one slow cycle, with `wdg_count` = 0. In the following slow cycle `wdg_count` holds the active reload value and `wdg_running` stays 1.
- R3: Key 0xAAAA copies the active reload value into the counter and restarts the prescaler. Before the start key, it leaves the counter at 0xFFF and the watchdog stopped.
- R4: Key 0x5555 unlocks the prescaler register (address 1, bits 2:0) and the reload register (address 2, bits 11:0). Any other key write locks them again. While they are locked, writes to them change neither the readback nor the status register.
- R5: After the start key, `osc_force_on` and `wdg_running` stay 1 whatever keys are written later.
- R6: With prescaler code c, the counter decrements once every 4·2^c slow cycles for c = 0 to 5. Codes 6 and 7 both give 256.
- R7: The status register at address 3 has bit 0 for a prescaler update pending and bit 1 for a reload update pending. A bit is set by an accepted write and clears once the slow domain has taken the value. While a bit is set, further writes to that register are ignored.
- R8: While `dbg_halt` is high, the counter holds its value. When `dbg_halt` is low, counting resumes.
- R9: Key values other than 0xCCCC, 0xAAAA and 0x5555 have no effect except re-locking the configuration registers.
- R10: After reset, the prescaler reads 0, the reload reads 0xFFF, the status reads 0, `wdg_count` is 0xFFF, and `wdg_running`, `osc_force_on` and `wdg_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| lclk | input | 1 | Slow free-running clock |
| lrst_n | input | 1 | Slow-domain synchronous reset, active low |
| dbg_halt | input | 1 | Debug freeze, synchronous to `lclk` |
| osc_force_on | output | 1 | Request to keep the slow oscillator running |
| wdg_running | output | 1 | Watchdog started (slow domain) |
| wdg_count | output | 12 | Current counter value (slow domain) |
| wdg_rst | output | 1 | One-slow-cycle expiry reset pulse |

## Verification
The bench uses the default parameters: a 12-bit counter and two-stage synchronisers. The slow clock runs five times slower than the bus clock, so every handshake really crosses clock domains.

Expiry from the full 0xFFF count is not awaited. Instead, the bench programs a reload of 0x010 with prescaler code 0, which brings the reset pulse within 64 slow cycles. The largest divide of 256 is still measured directly, tick to tick.

// File: rtl/wdt_pkg.sv
// Shared constants and helpers for the keyed watchdog.
// Assumes a 16-bit key word and a 3-bit prescaler code.
package wdt_pkg;
    localparam int KEY_W = 16;
    localparam int PRE_W = 3;
    localparam int DIV_W = 8;
    localparam int ADR_W = 2;

    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_KICK   = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;

    localparam logic [ADR_W-1:0] A_KEY = 2'd0;
    localparam logic [ADR_W-1:0] A_PRE = 2'd1;
    localparam logic [ADR_W-1:0] A_RLD = 2'd2;
    localparam logic [ADR_W-1:0] A_STS = 2'd3;

    // Terminal value of the prescale counter for a given code (divide - 1).
    function automatic logic [DIV_W-1:0] pre_limit(input logic [PRE_W-1:0] code);
        logic [DIV_W:0] d;
        d = (DIV_W+1)'(4);
        if (code >= PRE_W'(6)) d = (DIV_W+1)'(256);
        else                   d = d << code;
        return DIV_W'(d - (DIV_W+1)'(1));
    endfunction
endpackage

// File: rtl/wdt_sync.sv
// Multi-bit flop synchroniser for toggle signals.
// Assumes each bit is a slowly changing level (a toggle), so bits may be
// synchronised independently of one another.
module wdt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
// Bus-domain register file of the watchdog: key decode, write lock,
// holding registers, request toggles and pending flags.
// Assumes the ack inputs are already synchronised to clk.
module wdt_bus_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [KEY_W-1:0] bus_wdata,
    output logic [KEY_W-1:0] bus_rdata,
    input  logic             ack_pre_s,
    input  logic             ack_rld_s,
    output logic             start_tgl,
    output logic             kick_tgl,
    output logic             pre_tgl,
    output logic             rld_tgl,
    output logic [PRE_W-1:0] pre_val,
    output logic [CNT_W-1:0] rld_val,
    output logic             started
);
    logic unlock;
    logic pre_busy, rld_busy;
    logic key_wr, pre_wr, rld_wr;

    // A request is pending while the slow side has not echoed its toggle.
    assign pre_busy = pre_tgl ^ ack_pre_s;
    assign rld_busy = rld_tgl ^ ack_rld_s;

    assign key_wr = bus_we && (bus_addr == A_KEY);
    assign pre_wr = bus_we && (bus_addr == A_PRE) && unlock && !pre_busy;
    assign rld_wr = bus_we && (bus_addr == A_RLD) && unlock && !rld_busy;

    // Decode key writes into lock state, start and refresh requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock    <= 1'b0;
            started   <= 1'b0;
            start_tgl <= 1'b0;
            kick_tgl  <= 1'b0;
        end else if (key_wr) begin
            unlock <= (bus_wdata == KEY_UNLOCK);
            if (bus_wdata == KEY_START && !started) begin
                started   <= 1'b1;
                start_tgl <= ~start_tgl;
            end
            if (bus_wdata == KEY_KICK) kick_tgl <= ~kick_tgl;
        end
    end

    // Capture accepted configuration writes and raise their requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_val <= '0;
            rld_val <= '1;
            pre_tgl <= 1'b0;
            rld_tgl <= 1'b0;
        end else begin
            if (pre_wr) begin
                pre_val <= bus_wdata[PRE_W-1:0];
                pre_tgl <= ~pre_tgl;
            end
            if (rld_wr) begin
                rld_val <= bus_wdata[CNT_W-1:0];
                rld_tgl <= ~rld_tgl;
            end
        end
    end

    // Read multiplexer for the register file.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PRE:   bus_rdata[PRE_W-1:0] = pre_val;
            A_RLD:   bus_rdata[CNT_W-1:0] = rld_val;
            A_STS:   bus_rdata[1:0]       = {rld_busy, pre_busy};
            default: bus_rdata            = '0;
        endcase
    end

    // R4
    locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PRE && !unlock) |=> $stable(pre_val));
    // R4
    locked_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_RLD && !unlock) |=> $stable(rld_val));
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_busy && bus_we && bus_addr == A_PRE) |=> $stable(pre_val));
    // R9
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> $past(key_wr && bus_wdata == KEY_UNLOCK));
    // R5
    started_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> started);
endmodule

// File: rtl/wdt_core.sv
// Slow-domain watchdog engine: takes synchronised requests, applies
// configuration, runs the prescaler and the down-counter, fires the reset.
// Assumes the request toggles are synchronised to lclk, the value buses are
// held stable while their requests are pending, and dbg_halt is synchronous.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             lclk,
    input  logic             lrst_n,
    input  logic             start_t,
    input  logic             kick_t,
    input  logic             pre_t,
    input  logic             rld_t,
    input  logic [PRE_W-1:0] pre_val,
    input  logic [CNT_W-1:0] rld_val,
    input  logic             dbg_halt,
    output logic             ack_pre,
    output logic             ack_rld,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             wdg_rst
);
    logic             start_ack, kick_ack;
    logic             start_ev, kick_ev;
    logic [PRE_W-1:0] pre_act;
    logic [CNT_W-1:0] rld_act;
    logic [DIV_W-1:0] div_cnt, div_lim;
    logic             tick;

    assign start_ev = start_t ^ start_ack;
    assign kick_ev  = kick_t ^ kick_ack;
    assign div_lim  = pre_limit(pre_act);
    assign tick     = running && !dbg_halt && (div_cnt >= div_lim);

    // Consume request toggles and take configuration values.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            start_ack <= 1'b0;
            kick_ack  <= 1'b0;
            ack_pre   <= 1'b0;
            ack_rld   <= 1'b0;
            pre_act   <= '0;
            rld_act   <= '1;
        end else begin
            start_ack <= start_t;
            kick_ack  <= kick_t;
            if (pre_t != ack_pre) begin
                pre_act <= pre_val;
                ack_pre <= pre_t;
            end
            if (rld_t != ack_rld) begin
                rld_act <= rld_val;
                ack_rld <= rld_t;
            end
        end
    end

    // Prescaler, down-counter and expiry pulse.
    always_ff @(posedge lclk) begin
        if (!lrst_n) begin
            running <= 1'b0;
            cnt     <= '1;
            div_cnt <= '0;
            wdg_rst <= 1'b0;
        end else begin
            wdg_rst <= 1'b0;
            if (start_ev && !running) begin
                running <= 1'b1;
                cnt     <= '1;
                div_cnt <= '0;
            end else if (running) begin
                if (wdg_rst) begin
                    cnt <= rld_act;
                end else if (kick_ev) begin
                    cnt     <= rld_act;
                    div_cnt <= '0;
                end else if (!dbg_halt) begin
                    if (tick) begin
                        div_cnt <= '0;
                        if (cnt <= CNT_W'(1)) begin
                            cnt     <= '0;
                            wdg_rst <= 1'b1;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
            end
        end
    end

    // R2
    pulse_zero_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
        wdg_rst |-> (cnt == '0));
    // R2
    pulse_width_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
        wdg_rst |=> !wdg_rst);
    // R5
    no_stop_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
        running |=> running);
    // R8
    freeze_hold_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
        (running && dbg_halt && !kick_ev && !wdg_rst) |=> $stable(cnt));
    // R6
    count_down_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
        (running && !kick_ev && !wdg_rst) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/wdt_keyed.sv
// Top of the keyed watchdog: bus-domain registers, clock-domain crossing
// of requests and acknowledgements, and the slow-domain engine.
// Assumes clk and lclk are unrelated; each reset is synchronous to its clock.
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic             lclk,
    input  logic             lrst_n,
    input  logic             dbg_halt,
    output logic             osc_force_on,
    output logic             wdg_running,
    output logic [CNT_W-1:0] wdg_count,
    output logic             wdg_rst
);
    logic             start_tgl, kick_tgl, pre_tgl, rld_tgl;
    logic [3:0]       req_s;
    logic [1:0]       ack_l, ack_s;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] rld_val;
    logic             started;

    wdt_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ack_pre_s(ack_s[0]), .ack_rld_s(ack_s[1]),
        .start_tgl(start_tgl), .kick_tgl(kick_tgl),
        .pre_tgl(pre_tgl), .rld_tgl(rld_tgl),
        .pre_val(pre_val), .rld_val(rld_val), .started(started)
    );

    wdt_sync #(.WIDTH(4), .STAGES(SYNC_N)) u_req_sync (
        .clk(lclk), .rst_n(lrst_n),
        .d({rld_tgl, pre_tgl, kick_tgl, start_tgl}), .q(req_s)
    );

    wdt_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_l), .q(ack_s)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .lclk(lclk), .lrst_n(lrst_n),
        .start_t(req_s[0]), .kick_t(req_s[1]),
        .pre_t(req_s[2]), .rld_t(req_s[3]),
        .pre_val(pre_val), .rld_val(rld_val),
        .dbg_halt(dbg_halt),
        .ack_pre(ack_l[0]), .ack_rld(ack_l[1]),
        .running(wdg_running), .cnt(wdg_count), .wdg_rst(wdg_rst)
    );

    assign osc_force_on = started;
endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;
    logic        clk = 1'b0, lclk = 1'b0;
    logic        rst_n = 1'b0, lrst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        osc_force_on, wdg_running, wdg_rst;
    logic [11:0] wdg_count;

    int checks = 0;
    int fails  = 0;

    always #4  clk  = ~clk;
    always #20 lclk = ~lclk;

    wdt_keyed uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lclk(lclk),
        .lrst_n(lrst_n), .dbg_halt(dbg_halt), .osc_force_on(osc_force_on),
        .wdg_running(wdg_running), .wdg_count(wdg_count), .wdg_rst(wdg_rst)
    );

    // {write addr, write data, readback addr, expected}
    localparam logic [35:0] TBL [10] = '{
        {2'd1, 16'h0005, 2'd1, 16'h0000},   // R4 locked prescaler write
        {2'd2, 16'h0123, 2'd2, 16'h0FFF},   // R4 locked reload write
        {2'd0, 16'h5555, 2'd3, 16'h0000},   // R4 unlock, nothing pending
        {2'd1, 16'h0002, 2'd3, 16'h0001},   // R7 prescaler pending
        {2'd0, 16'h5555, 2'd1, 16'h0002},   // R4 prescaler readback
        {2'd2, 16'h0040, 2'd3, 16'h0002},   // R7 reload pending
        {2'd0, 16'h1234, 2'd2, 16'h0040},   // R9 unknown key
        {2'd2, 16'h0007, 2'd2, 16'h0040},   // R9 relocked by unknown key
        {2'd0, 16'h5555, 2'd3, 16'h0000},   // R4 unlock again
        {2'd1, 16'h0006, 2'd1, 16'h0006}    // R4 prescaler code 6
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(2'd3, v);
            if (v == 16'h0) return;
        end
        check(req, int'(v), 0);
    endtask

    task automatic measure(input string req, input int exp);
        logic [11:0] prev;
        int n;
        @(negedge lclk);
        prev = wdg_count;
        for (int i = 0; i < 600 && wdg_count == prev; i++) @(negedge lclk);
        prev = wdg_count;
        n = 0;
        for (int i = 0; i < 600 && wdg_count == prev; i++) begin
            @(negedge lclk);
            n++;
        end
        check(req, n, exp);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [11:0] held;
        repeat (4) @(negedge lclk);
        rst_n = 1'b1; lrst_n = 1'b1;
        @(negedge lclk);

        // R10 reset state
        rd(2'd1, v); check("R10 prescaler", int'(v), 0);
        rd(2'd2, v); check("R10 reload", int'(v), 'hFFF);
        rd(2'd3, v); check("R10 status", int'(v), 0);
        check("R10 count", int'(wdg_count), 'hFFF);
        check("R10 running/force/rst",
              int'({wdg_running, osc_force_on, wdg_rst}), 0);

        // Table of register-access vectors
        for (int i = 0; i < 10; i++) begin
            wr(TBL[i][35:34], TBL[i][33:18]);
            rd(TBL[i][17:16], v);
            check($sformatf("R4/R7/R9 row %0d", i), int'(v), int'(TBL[i][15:0]));
            wait_idle("R7 pending clears");
        end

        // R7 second write while pending is dropped
        wr(2'd1, 16'h0003);
        wr(2'd1, 16'h0004);
        wait_idle("R7 pending clears");
        rd(2'd1, v); check("R7 write while pending ignored", int'(v), 3);
        wr(2'd2, 16'h0010); wait_idle("R7 pending clears");
        wr(2'd1, 16'h0000); wait_idle("R7 pending clears");

        // R3 refresh before start has no effect
        wr(2'd0, 16'hAAAA);
        repeat (10) @(negedge lclk);
        check("R3 kick before start", int'({wdg_running, wdg_count}), 'h0FFF);

        // R1 and R5 start
        wr(2'd0, 16'hCCCC);
        check("R5 force on after start", int'(osc_force_on), 1);
        for (int i = 0; i < 50 && !wdg_running; i++) @(negedge lclk);
        check("R1 running", int'(wdg_running), 1);
        check("R1 start count", int'(wdg_count), 'hFFF);

        // R6 prescaler periods
        measure("R6 code 0", 4);
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0002); wait_idle("R7 pending clears");
        measure("R6 code 2", 16);
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0007); wait_idle("R7 pending clears");
        measure("R6 code 7", 256);

        // R3 refresh after start
        wr(2'd0, 16'hAAAA);
        repeat (12) @(negedge lclk);
        check("R3 kick reloads", int'(wdg_count), 'h010);

        // R8 debug freeze
        dbg_halt = 1'b1;
        @(negedge lclk);
        held = wdg_count;
        repeat (600) @(negedge lclk);
        check("R8 frozen", int'(wdg_count), int'(held));
        dbg_halt = 1'b0;
        repeat (600) @(negedge lclk);
        check("R8 resumes", int'(wdg_count < held), 1);

        // R2 expiry
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0000); wait_idle("R7 pending clears");
        wr(2'd0, 16'hAAAA);
        for (int i = 0; i < 2000 && !wdg_rst; i++) @(negedge lclk);
        check("R2 pulse seen", int'(wdg_rst), 1);
        check("R2 count zero at pulse", int'(wdg_count), 0);
        @(negedge lclk);
        check("R2 pulse one cycle", int'(wdg_rst), 0);
        check("R2 reload after pulse", int'(wdg_count), 'h010);
        check("R2 still running", int'(wdg_running), 1);

        // R5 and R9 stop attempts and unknown keys
        wr(2'd0, 16'h0000); wr(2'd0, 16'hFFFF); wr(2'd0, 16'h1234);
        repeat (20) @(negedge lclk);
        check("R5 cannot stop", int'({wdg_running, osc_force_on}), 3);
        rd(2'd2, v); check("R9 unknown keys keep reload", int'(v), 'h010);

        summary();
        $finish;
    end
endmodule